// File: doc/BRIEF.md
# Battery Pack Presence Probe Sequencer

This block decides whether a removable battery pack is still attached to the charger output. A charge controller starts it in one of two ways. It raises `start_probe` when the battery voltage has sagged to the recharge threshold after a completed charge, which can mean a load or a pulled pack. It raises `term_event` when charge termination has just been detected. The block then drives one of three current enables in turn: a termination discharge sink, a probe discharge sink and a wake source. It reads two digitised comparator flags, one for "below the short threshold" and one for "above the recharge threshold", and reports its verdict to the controller.

A probe has two timed phases. The discharge phase sinks current for `DISCH_MS` ticks and passes if the output has collapsed below the short threshold. The wake phase then sources current for `WAKE_MS` ticks and passes if the output has risen above the recharge threshold, which is what an empty output node does. An attached pack, or a pack whose protector switch is just closing, does neither. When both phases pass, the pack is declared absent and the probe starts again at once, and it keeps repeating for as long as nothing is attached. When a phase fails, the block sends a single start-charge pulse. After a termination event, a termination sink runs for `TERM_MS` ticks first, and a probe follows only if the output has dropped to the recharge threshold. All durations count a 1 ms tick input, and an abort input returns the block to idle at any time.

Top module: `pack_probe_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block goes idle: `dis_en`, `wake_en`, `term_dis_en`, `pack_absent` and `start_charge` are all 0 after that edge.
- R2: In idle, `start_probe` sets `dis_en` to 1 from the next clock edge. `dis_en` stays 1 for exactly `DISCH_MS` cycles in which `tick_ms` is 1, and cycles with `tick_ms` at 0 do not advance the phase.
- R3: If `below_short` is 0 on the final tick of the discharge phase, the block returns to idle with all enables at 0, clears `pack_absent` and drives `start_charge` to 1 for exactly one cycle.
- R4: If `below_short` is 1 on the final discharge tick, `wake_en` is 1 from the next edge for exactly `WAKE_MS` ticks, and `dis_en` is 0.
- R5: If `above_rchg` is 0 on the final wake tick, the block returns to idle, clears `pack_absent` and pulses `start_charge` for one cycle.
- R6: If `above_rchg` is 1 on the final wake tick, `pack_absent` becomes 1 and a new discharge phase starts on the same edge, with no `start_charge` pulse.
- R7: In idle, `term_event` sets `term_dis_en` for exactly `TERM_MS` ticks. On its final tick, if `above_rchg` is 0 a discharge phase follows. If `above_rchg` is 1 the block goes idle with no `start_charge` pulse and `pack_absent` unchanged.
- R8: At most one of `dis_en`, `wake_en` and `term_dis_en` is 1 in any cycle.
- R9: `abort` at a clock edge returns the block to idle: all enables, `pack_absent` and `start_charge` are 0 after that edge.
- R10: Each comparator flag decides its phase only through its value on that phase's final tick. Values on earlier ticks have no effect.
- R11: `start_probe` and `term_event` are ignored while a phase is running. The running phase keeps its full length and its outcome.
- R12: When `term_event` and `start_probe` are both 1 in the same idle cycle, the termination discharge phase is the one started.
- R13: While the pack stays absent, the probe keeps repeating with `pack_absent` held at 1 and no `start_charge` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_ms | input | 1 | One-cycle pulse every millisecond; phases count these |
| start_probe | input | 1 | Battery voltage has fallen to the recharge threshold after a charge |
| term_event | input | 1 | Charge termination detected |
| abort | input | 1 | Supply loss or charge disable; forces idle |
| below_short | input | 1 | Digitised flag: output below the short-circuit threshold |
| above_rchg | input | 1 | Digitised flag: output above the recharge threshold |
| dis_en | output | 1 | Probe discharge sink enable |
| wake_en | output | 1 | Wake current source enable |
| term_dis_en | output | 1 | Termination discharge sink enable |
| pack_absent | output | 1 | Level: last complete probe found no pack |
| start_charge | output | 1 | One-cycle pulse: a probe check failed, begin a new charge |

## Verification
The probe runs against flag patterns that model an attached pack (the output never collapses), an empty node (both checks pass, repeated over several rounds), and a pack that answers only in the wake phase. Together these separate the three outcomes: absent, start-charge at discharge, and start-charge at wake. Flags held at one value for the whole phase and then flipped on the final tick show that only the final tick is sampled, and a stretch with the tick held low shows that the phase counts ticks rather than clock cycles. The termination path is driven with both final flag values. Start requests sent during a phase, simultaneous requests and aborts in the middle of a phase show which input wins.

// File: rtl/pack_probe_pkg.sv
// Shared definitions for the pack presence probe sequencer.
// Assumes: exactly three current enables, indexed as listed below.
package pack_probe_pkg;

    typedef enum logic [1:0] {
        PS_IDLE  = 2'd0,
        PS_TERM  = 2'd1,
        PS_DISCH = 2'd2,
        PS_WAKE  = 2'd3
    } probe_state_e;

    localparam int unsigned EN_COUNT = 3;
    localparam int unsigned EN_DIS   = 0;
    localparam int unsigned EN_WAKE  = 1;
    localparam int unsigned EN_TERM  = 2;

    // State in which enable bit idx is driven.
    function automatic probe_state_e en_state(input int unsigned idx);
        case (idx)
            EN_DIS:  return PS_DISCH;
            EN_WAKE: return PS_WAKE;
            default: return PS_TERM;
        endcase
    endfunction

endpackage

// File: rtl/phase_timer.sv
// Tick counter for one timed phase.
// Counts tick pulses from zero and raises done on the tick that completes
// len_m1+1 ticks, then restarts at zero. clear holds the count at zero.
// Assumes: len_m1 is stable during a phase.
module phase_timer #(
    parameter int unsigned CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic [CNT_W-1:0] len_m1,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    // Final tick of the phase.
    assign done = tick && !clear && (cnt_q == len_m1);

    // Tick counter with clear and wrap on completion.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= done ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/probe_fsm.sv
// Sequencing and verdict logic for the pack presence probe.
// Moves between idle, termination discharge, probe discharge and wake.
// Comparator flags are read only when phase_done marks a phase's final tick.
// Assumes: phase_done comes from a timer cleared in idle.
module probe_fsm
    import pack_probe_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         abort,
    input  logic         start_probe,
    input  logic         term_event,
    input  logic         below_short,
    input  logic         above_rchg,
    input  logic         phase_done,
    output probe_state_e state,
    output logic         start_charge,
    output logic         pack_absent
);

    probe_state_e state_d;
    logic         pulse_d;
    logic         absent_d;

    // Next state and verdict outputs.
    always_comb begin
        state_d  = state;
        pulse_d  = 1'b0;
        absent_d = pack_absent;
        case (state)
            PS_IDLE: begin
                if (term_event) begin
                    state_d = PS_TERM;
                end else if (start_probe) begin
                    state_d = PS_DISCH;
                end
            end
            PS_TERM: begin
                if (phase_done) begin
                    state_d = above_rchg ? PS_IDLE : PS_DISCH;
                end
            end
            PS_DISCH: begin
                if (phase_done) begin
                    if (below_short) begin
                        state_d = PS_WAKE;
                    end else begin
                        state_d  = PS_IDLE;
                        pulse_d  = 1'b1;
                        absent_d = 1'b0;
                    end
                end
            end
            PS_WAKE: begin
                if (phase_done) begin
                    if (above_rchg) begin
                        state_d  = PS_DISCH;
                        absent_d = 1'b1;
                    end else begin
                        state_d  = PS_IDLE;
                        pulse_d  = 1'b1;
                        absent_d = 1'b0;
                    end
                end
            end
            default: state_d = PS_IDLE;
        endcase
        if (abort) begin
            state_d  = PS_IDLE;
            pulse_d  = 1'b0;
            absent_d = 1'b0;
        end
    end

    // State and verdict registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= PS_IDLE;
            start_charge <= 1'b0;
            pack_absent  <= 1'b0;
        end else begin
            state        <= state_d;
            start_charge <= pulse_d;
            pack_absent  <= absent_d;
        end
    end

endmodule

// File: rtl/enable_decode.sv
// Maps the sequencer state to the current enables, one bit per source.
// Each bit is high only in its own state, so at most one is high.
module enable_decode
    import pack_probe_pkg::*;
(
    input  probe_state_e         state,
    output logic [EN_COUNT-1:0]  en
);

    // One comparator per enable.
    for (genvar g = 0; g < EN_COUNT; g++) begin : g_en
        assign en[g] = (state == en_state(g));
    end

endmodule

// File: rtl/pack_probe_seq.sv
// Top of the pack presence probe sequencer.
// Runs a termination discharge (optional), then a discharge check and a wake
// check, and either flags an absent pack and repeats or requests a new charge.
// Assumes: tick_ms is a single-cycle pulse; all phase lengths are at least 1.
module pack_probe_seq
    import pack_probe_pkg::*;
#(
    parameter int unsigned TERM_MS  = 262,
    parameter int unsigned DISCH_MS = 1000,
    parameter int unsigned WAKE_MS  = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_ms,
    input  logic start_probe,
    input  logic term_event,
    input  logic abort,
    input  logic below_short,
    input  logic above_rchg,
    output logic dis_en,
    output logic wake_en,
    output logic term_dis_en,
    output logic pack_absent,
    output logic start_charge
);

    localparam int unsigned MAX_A  = (TERM_MS > DISCH_MS) ? TERM_MS : DISCH_MS;
    localparam int unsigned MAX_MS = (MAX_A > WAKE_MS) ? MAX_A : WAKE_MS;
    localparam int unsigned CNT_W  = (MAX_MS > 1) ? $clog2(MAX_MS) : 1;

    probe_state_e         state;
    logic                 phase_done;
    logic                 tmr_clear;
    logic [CNT_W-1:0]     len_m1;
    logic [EN_COUNT-1:0]  en;

    // Phase length for the current state.
    always_comb begin
        case (state)
            PS_TERM:  len_m1 = CNT_W'(TERM_MS - 1);
            PS_WAKE:  len_m1 = CNT_W'(WAKE_MS - 1);
            default:  len_m1 = CNT_W'(DISCH_MS - 1);
        endcase
    end

    assign tmr_clear = (state == PS_IDLE) || abort;

    phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (tmr_clear),
        .tick   (tick_ms),
        .len_m1 (len_m1),
        .done   (phase_done)
    );

    probe_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .abort        (abort),
        .start_probe  (start_probe),
        .term_event   (term_event),
        .below_short  (below_short),
        .above_rchg   (above_rchg),
        .phase_done   (phase_done),
        .state        (state),
        .start_charge (start_charge),
        .pack_absent  (pack_absent)
    );

    enable_decode u_dec (
        .state (state),
        .en    (en)
    );

    assign dis_en      = en[EN_DIS];
    assign wake_en     = en[EN_WAKE];
    assign term_dis_en = en[EN_TERM];

endmodule

// File: rtl/pack_probe_chk.sv
// Property checker for pack_probe_seq, attached by bind below.
module pack_probe_chk (
    input logic clk,
    input logic rst_n,
    input logic start_probe,
    input logic term_event,
    input logic abort,
    input logic below_short,
    input logic dis_en,
    input logic wake_en,
    input logic term_dis_en,
    input logic pack_absent,
    input logic start_charge
);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> !dis_en && !wake_en && !term_dis_en && !pack_absent && !start_charge);

    // R8
    one_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({dis_en, wake_en, term_dis_en}) <= 1);

    // R9
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !dis_en && !wake_en && !term_dis_en && !pack_absent && !start_charge);

    // R3
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_charge |=> !start_charge);

    // R6
    absent_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pack_absent) |-> dis_en && !start_charge);

    // R4
    wake_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_en) |-> $past(dis_en) && $past(below_short));

    // R2
    disch_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dis_en) |-> $past(start_probe) || $past(wake_en) || $past(term_dis_en));

    // R12
    term_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(term_dis_en) |-> $past(term_event));

endmodule

bind pack_probe_seq pack_probe_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_probe  (start_probe),
    .term_event   (term_event),
    .abort        (abort),
    .below_short  (below_short),
    .dis_en       (dis_en),
    .wake_en      (wake_en),
    .term_dis_en  (term_dis_en),
    .pack_absent  (pack_absent),
    .start_charge (start_charge)
);

// File: tb/test_pack_probe_seq.sv
module test_pack_probe_seq;

    localparam int TERM_L = 5;
    localparam int DIS_L  = 8;
    localparam int WAKE_L = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_ms = 1'b1;
    logic start_probe = 1'b0;
    logic term_event = 1'b0;
    logic abort = 1'b0;
    logic below_short = 1'b0;
    logic above_rchg = 1'b0;
    logic dis_en, wake_en, term_dis_en, pack_absent, start_charge;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    pack_probe_seq #(
        .TERM_MS  (TERM_L),
        .DISCH_MS (DIS_L),
        .WAKE_MS  (WAKE_L)
    ) i_pack_probe_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_ms      (tick_ms),
        .start_probe  (start_probe),
        .term_event   (term_event),
        .abort        (abort),
        .below_short  (below_short),
        .above_rchg   (above_rchg),
        .dis_en       (dis_en),
        .wake_en      (wake_en),
        .term_dis_en  (term_dis_en),
        .pack_absent  (pack_absent),
        .start_charge (start_charge)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Outputs packed as {dis, wake, term, absent, pulse}.
    function automatic int outs();
        return {27'd0, dis_en, wake_en, term_dis_en, pack_absent, start_charge};
    endfunction

    task automatic report();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Issue one idle request cycle; returns at the negedge after the edge.
    task automatic kick(input bit probe, input bit term);
        start_probe = probe;
        term_event  = term;
        @(negedge clk);
        start_probe = 1'b0;
        term_event  = 1'b0;
    endtask

    // Run one phase from its first negedge. kind: 0 discharge, 1 wake, 2 term.
    // The flag is mid on all ticks but the last, fin on the last.
    task automatic run_phase(input int kind, input int len, input bit mid, input bit fin,
                             input bit poke, input string req);
        int on_cnt = 0;
        for (int i = 0; i < len; i++) begin
            if (kind == 0) below_short = (i == len - 1) ? fin : mid;
            else           above_rchg  = (i == len - 1) ? fin : mid;
            if (poke && i == 1) begin
                start_probe = 1'b1;
                term_event  = 1'b1;
            end else begin
                start_probe = 1'b0;
                term_event  = 1'b0;
            end
            if ((kind == 0 && dis_en) || (kind == 1 && wake_en) || (kind == 2 && term_dis_en))
                on_cnt++;
            @(negedge clk);
        end
        start_probe = 1'b0;
        term_event  = 1'b0;
        check(on_cnt == len, req, on_cnt, len);
    endtask

    task automatic t_reset();
        check(outs() == 0, "R1 reset state", outs(), 0);
    endtask

    task automatic t_present_pack();
        kick(1'b1, 1'b0);
        run_phase(0, DIS_L, 1'b0, 1'b0, 1'b0, "R2 discharge length");
        check(outs() == 1, "R3 discharge fail pulse", outs(), 1);
        @(negedge clk);
        check(outs() == 0, "R3 pulse one cycle then idle", outs(), 0);
    endtask

    task automatic t_absent_loop();
        kick(1'b1, 1'b0);
        run_phase(0, DIS_L, 1'b1, 1'b1, 1'b0, "R2 discharge length");
        check(outs() == 5'b01000, "R4 wake entered", outs(), 5'b01000);
        run_phase(1, WAKE_L, 1'b1, 1'b1, 1'b0, "R4 wake length");
        check(outs() == 5'b10010, "R6 absent and new probe", outs(), 5'b10010);
        for (int r = 0; r < 2; r++) begin
            run_phase(0, DIS_L, 1'b1, 1'b1, 1'b0, "R13 repeat discharge length");
            check(outs() == 5'b01010, "R13 absent held in wake", outs(), 5'b01010);
            run_phase(1, WAKE_L, 1'b1, 1'b1, 1'b0, "R13 repeat wake length");
            check(outs() == 5'b10010, "R13 absent held, no pulse", outs(), 5'b10010);
        end
        run_phase(0, DIS_L, 1'b1, 1'b1, 1'b0, "R2 discharge length");
        run_phase(1, WAKE_L, 1'b1, 1'b0, 1'b0, "R4 wake length");
        check(outs() == 1, "R5 wake fail pulse, absent cleared", outs(), 1);
        @(negedge clk);
    endtask

    task automatic t_tick_gate();
        int held = 0;
        kick(1'b1, 1'b0);
        tick_ms = 1'b0;
        for (int i = 0; i < 20; i++) begin
            if (dis_en) held++;
            @(negedge clk);
        end
        check(held == 20, "R2 no advance without tick", held, 20);
        tick_ms = 1'b1;
        run_phase(0, DIS_L, 1'b0, 1'b0, 1'b0, "R2 discharge length in ticks");
        check(outs() == 1, "R3 fail after gated ticks", outs(), 1);
        @(negedge clk);
    endtask

    task automatic t_final_tick_only();
        kick(1'b1, 1'b0);
        run_phase(0, DIS_L, 1'b1, 1'b0, 1'b0, "R10 discharge length");
        check(outs() == 1, "R10 late short flag decides", outs(), 1);
        @(negedge clk);
        kick(1'b1, 1'b0);
        run_phase(0, DIS_L, 1'b0, 1'b1, 1'b0, "R10 discharge length");
        check(outs() == 5'b01000, "R10 short flag only on last tick", outs(), 5'b01000);
        run_phase(1, WAKE_L, 1'b1, 1'b0, 1'b0, "R10 wake length");
        check(outs() == 1, "R10 late recharge flag decides", outs(), 1);
        @(negedge clk);
    endtask

    task automatic t_ignore_busy();
        kick(1'b1, 1'b0);
        run_phase(0, DIS_L, 1'b1, 1'b1, 1'b1, "R11 discharge length with requests");
        check(outs() == 5'b01000, "R11 outcome kept", outs(), 5'b01000);
        run_phase(1, WAKE_L, 1'b0, 1'b0, 1'b1, "R11 wake length with requests");
        check(outs() == 1, "R11 wake outcome kept", outs(), 1);
        @(negedge clk);
    endtask

    task automatic t_termination();
        above_rchg = 1'b0;
        kick(1'b0, 1'b1);
        run_phase(2, TERM_L, 1'b1, 1'b0, 1'b0, "R7 term length");
        check(outs() == 5'b10000, "R7 low output starts probe", outs(), 5'b10000);
        run_phase(0, DIS_L, 1'b0, 1'b0, 1'b0, "R7 following discharge");
        @(negedge clk);
        kick(1'b0, 1'b1);
        run_phase(2, TERM_L, 1'b0, 1'b1, 1'b0, "R7 term length");
        check(outs() == 0, "R7 pack held up, idle no pulse", outs(), 0);
        kick(1'b1, 1'b1);
        check(outs() == 5'b00100, "R12 term wins", outs(), 5'b00100);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        check(outs() == 0, "R9 abort in term phase", outs(), 0);
    endtask

    task automatic t_abort();
        kick(1'b1, 1'b0);
        run_phase(0, DIS_L, 1'b1, 1'b1, 1'b0, "R2 discharge length");
        run_phase(1, WAKE_L, 1'b1, 1'b1, 1'b0, "R4 wake length");
        check(pack_absent == 1'b1, "R6 absent before abort", pack_absent, 1);
        repeat (3) @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        check(outs() == 0, "R9 abort clears absent and enables", outs(), 0);
        repeat (3) @(negedge clk);
        check(outs() == 0, "R9 stays idle after abort", outs(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_present_pack();
        t_absent_loop();
        t_tick_gate();
        t_final_tick_only();
        t_ignore_busy();
        t_termination();
        t_abort();
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=0 expected=1");
            report();
        end
    end

endmodule